// File: doc/BRIEF.md
# Two-Level Weighted Bandwidth Sharer

This block hands out bandwidth, one grant token per clock cycle, to a set of requesters grouped under several tenants. Each tenant is one independent configuration view of a shared resource, and each tenant owns a fixed number of traffic classes. A requester is identified by its flat index k = tenant * N_CLS + class. Time is cut into accounting intervals of INTERVAL cycles. At the start of each interval, every tenant and every class gets its reserved token budget back.

A grant is first drawn from reserved budgets. Once no valid requester has reserved budget left at both its class and its tenant level, the spare cycle is shared in two stages. The first stage picks a tenant by tenant weight, and the second stage picks a class inside that tenant by class weight. Both stages use smooth weighted round-robin. A tenant whose weight is zero never takes part in the spare stage, so its reservation acts as a hard cap.

Configuration arrives as single-cycle commands. The tenant-limit command (opcode 4) may succeed only once per tenant after reset. The requester side is a valid/ready stream with one bit per requester. Ready is the grant, and a token is transferred when valid and ready are both high. A requester may raise or drop valid in any cycle. No back-pressure is stored: a valid that is not granted in a cycle carries no obligation into the next cycle.

Top module: `bwshare`

## Requirements
- R1: After reset, no requester is granted, cmd_done is low, and every tenant's reported reservable bandwidth equals INTERVAL.
- R2: Opcode 4 stores cmd_rbw and cmd_wgt as the reservation and weight of tenant cmd_tenant. It ignores cmd_class. On the next cycle, cmd_status is 0 and that tenant's cap_rbw field (bits t*TOK_W upward) equals cmd_rbw.
- R3: A second opcode 4 for the same tenant before the next reset returns status 2 and leaves that tenant's reservation, weight and cap_rbw unchanged.
- R4: Opcode 1 stores the reservation and weight of class cmd_class of tenant cmd_tenant, returns status 0, and may be repeated. Any other opcode returns status 1.
- R5: cmd_done is high in the cycle after each cycle with cmd_valid high, and low otherwise. cmd_status is valid while cmd_done is high.
- R6: At most one req_ready bit is high in any cycle, and only for a requester whose req_valid is high.
- R7: A valid requester is reserved-eligible when both its class budget and its tenant budget are non-zero. If any requester is reserved-eligible, the one with the lowest index is granted, and both budgets lose one token.
- R8: Every INTERVAL cycles after reset, all budgets reload from the configured reservations. A configuration change takes effect on budgets at the next reload.
- R9: A tenant with weight 0 receives no spare grants, so its requesters get at most its reservation per interval.
- R10: A spare grant goes to a contending tenant chosen by smooth weighted round-robin on tenant weight. Each contender's credit gains its weight, the highest credit wins with ties to the lowest index, and the winner's credit loses the sum of contending weights. A tenant contends when it has non-zero weight and a valid requester with non-zero class weight.
- R11: Inside the chosen tenant, the class is chosen by the same rule on class weight among its valid non-zero-weight classes. Weights 50 and 25 give a 2:1 split.
- R12: The sharer is work-conserving: whenever some requester is reserved-eligible or spare-eligible, exactly one grant is made.
- R13: All round-robin credits return to zero at each interval boundary, so identical request patterns repeat identical grant sequences in every interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 4 | Opcode: 1 set class, 4 set tenant limit |
| cmd_tenant | input | TI_W | Target tenant |
| cmd_class | input | CI_W | Target class (ignored by opcode 4) |
| cmd_rbw | input | TOK_W | Reserved tokens per interval |
| cmd_wgt | input | WGT_W | Weight for spare sharing |
| cmd_done | output | 1 | Command completed last cycle |
| cmd_status | output | 3 | 0 ok, 1 bad opcode, 2 limit already set |
| cap_rbw | output | N_TEN*TOK_W | Reported reservable bandwidth per tenant |
| req_valid | input | N_TEN*N_CLS | Per-requester request |
| req_ready | output | N_TEN*N_CLS | Per-requester grant, at most one high |

## Verification
The bench builds the block with two tenants of two classes each, 8-bit tokens and weights, and a 16-cycle interval. The short interval allows several budget reloads, and several checks that credits are cleared, to happen in a few hundred cycles. Two classes per tenant are enough to show the 2:1 class split, the 1:2 tenant split and the hard cap of a zero-weight tenant. The grant counts in each interval can be worked out by hand and are checked alongside a cycle-by-cycle model.

// File: rtl/bwshare_pkg.sv
package bwshare_pkg;
  localparam logic [3:0] OP_CLASS_SET    = 4'd1;
  localparam logic [3:0] OP_TENANT_LIMIT = 4'd4;

  typedef enum logic [2:0] {
    ST_OK     = 3'd0,
    ST_BADOP  = 3'd1,
    ST_LOCKED = 3'd2
  } bwshare_status_e;
endpackage

// File: rtl/bwshare_cfg.sv
module bwshare_cfg
  import bwshare_pkg::*;
#(
  parameter int N_TEN    = 2,
  parameter int N_CLS    = 2,
  parameter int TOK_W    = 8,
  parameter int WGT_W    = 8,
  parameter int INTERVAL = 16,
  localparam int N_REQ = N_TEN * N_CLS,
  localparam int TI_W  = (N_TEN > 1) ? $clog2(N_TEN) : 1,
  localparam int CI_W  = (N_CLS > 1) ? $clog2(N_CLS) : 1,
  localparam int RQ_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cmd_valid,
  input  logic [3:0]                         cmd_op,
  input  logic [TI_W-1:0]                    cmd_tenant,
  input  logic [CI_W-1:0]                    cmd_class,
  input  logic [TOK_W-1:0]                   cmd_rbw,
  input  logic [WGT_W-1:0]                   cmd_wgt,
  output logic                               cmd_done,
  output logic [2:0]                         cmd_status,
  output logic [N_TEN-1:0][TOK_W-1:0]        ten_rbw,
  output logic [N_TEN-1:0][WGT_W-1:0]        ten_wgt,
  output logic [N_REQ-1:0][TOK_W-1:0]        cls_rbw,
  output logic [N_REQ-1:0][WGT_W-1:0]        cls_wgt,
  output logic [N_TEN-1:0][TOK_W-1:0]        cap_rbw
);
  localparam logic [TI_W:0] TEN_LIM = (TI_W+1)'(N_TEN);
  localparam logic [CI_W:0] CLS_LIM = (CI_W+1)'(N_CLS);

  logic [N_TEN-1:0] locked;
  logic             ten_ok, cls_ok;
  logic [RQ_W-1:0]  ridx;

  assign ten_ok = ({1'b0, cmd_tenant} < TEN_LIM);
  assign cls_ok = ({1'b0, cmd_class} < CLS_LIM);
  assign ridx   = RQ_W'(cmd_tenant) * RQ_W'(N_CLS) + RQ_W'(cmd_class);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ten_rbw    <= '0;
      ten_wgt    <= '0;
      cls_rbw    <= '0;
      cls_wgt    <= '0;
      locked     <= '0;
      cmd_done   <= 1'b0;
      cmd_status <= ST_OK;
    end else begin
      cmd_done <= cmd_valid;
      if (cmd_valid) begin
        if (cmd_op == OP_TENANT_LIMIT && ten_ok) begin
          if (locked[cmd_tenant]) begin
            cmd_status <= ST_LOCKED;
          end else begin
            ten_rbw[cmd_tenant] <= cmd_rbw;
            ten_wgt[cmd_tenant] <= cmd_wgt;
            locked[cmd_tenant]  <= 1'b1;
            cmd_status          <= ST_OK;
          end
        end else if (cmd_op == OP_CLASS_SET && ten_ok && cls_ok) begin
          cls_rbw[ridx] <= cmd_rbw;
          cls_wgt[ridx] <= cmd_wgt;
          cmd_status    <= ST_OK;
        end else begin
          cmd_status <= ST_BADOP;
        end
      end
    end
  end

  for (genvar t = 0; t < N_TEN; t++) begin : g_cap
    assign cap_rbw[t] = locked[t] ? ten_rbw[t] : TOK_W'(INTERVAL);

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked[t] |=> (locked[t] && $stable(ten_rbw[t]) && $stable(ten_wgt[t])));

    // R2
    cap_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_TENANT_LIMIT && cmd_tenant == TI_W'(t) && !locked[t])
      |=> (cap_rbw[t] == $past(cmd_rbw) && cmd_status == ST_OK));
  end

  // R5
  cmd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> cmd_done);
endmodule

// File: rtl/bwshare_budget.sv
module bwshare_budget #(
  parameter int N_TEN    = 2,
  parameter int N_CLS    = 2,
  parameter int TOK_W    = 8,
  parameter int INTERVAL = 16,
  localparam int N_REQ = N_TEN * N_CLS,
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_TEN-1:0][TOK_W-1:0] ten_rbw,
  input  logic [N_REQ-1:0][TOK_W-1:0] cls_rbw,
  input  logic [N_REQ-1:0]            grant_res,
  output logic [N_TEN-1:0][TOK_W-1:0] ten_left,
  output logic [N_REQ-1:0][TOK_W-1:0] cls_left,
  output logic                        boundary
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt;

  assign boundary = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      ten_left <= '0;
      cls_left <= '0;
    end else if (boundary) begin
      cnt      <= '0;
      ten_left <= ten_rbw;
      cls_left <= cls_rbw;
    end else begin
      cnt <= cnt + 1'b1;
      for (int k = 0; k < N_REQ; k++) begin
        if (grant_res[k]) cls_left[k] <= cls_left[k] - 1'b1;
      end
      for (int t = 0; t < N_TEN; t++) begin
        if (|grant_res[t*N_CLS +: N_CLS]) ten_left[t] <= ten_left[t] - 1'b1;
      end
    end
  end

  for (genvar k = 0; k < N_REQ; k++) begin : g_cls_chk
    // R7
    cls_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_res[k] |-> (cls_left[k] != '0 && ten_left[k / N_CLS] != '0));
  end

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cls_left == $past(cls_rbw) && ten_left == $past(ten_rbw)));
endmodule

// File: rtl/bwshare_swrr.sv
module bwshare_swrr #(
  parameter int N     = 2,
  parameter int WGT_W = 8,
  localparam int CW = WGT_W + $clog2(N + 1) + 2,
  localparam int SW = CW + $clog2(N + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    advance,
  input  logic [N-1:0]            contend,
  input  logic [N-1:0][WGT_W-1:0] wgt,
  output logic [N-1:0]            pick,
  output logic                    any
);
  logic signed [CW-1:0] cred [N];
  logic signed [CW-1:0] tent [N];
  logic signed [CW-1:0] total;
  logic signed [CW-1:0] best;
  logic signed [SW-1:0] cred_sum;
  int                   win;

  always_comb begin
    total = '0;
    best  = '0;
    win   = 0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      tent[i] = cred[i] + $signed(CW'(wgt[i]));
      if (contend[i]) total = total + $signed(CW'(wgt[i]));
    end
    for (int i = 0; i < N; i++) begin
      if (contend[i] && (!any || tent[i] > best)) begin
        any  = 1'b1;
        best = tent[i];
        win  = i;
      end
    end
    for (int i = 0; i < N; i++) begin
      pick[i] = any && (i == win);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int i = 0; i < N; i++) cred[i] <= '0;
    end else if (advance && any) begin
      for (int i = 0; i < N; i++) begin
        if (contend[i]) cred[i] <= tent[i] - (pick[i] ? total : '0);
      end
    end
  end

  always_comb begin
    cred_sum = '0;
    for (int i = 0; i < N; i++) cred_sum = cred_sum + SW'(cred[i]);
  end

  // R10
  cred_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cred_sum == '0);

  // R13
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cred_sum == '0 && !$isunknown(pick)));
endmodule

// File: rtl/bwshare.sv
module bwshare #(
  parameter int N_TEN    = 2,
  parameter int N_CLS    = 2,
  parameter int TOK_W    = 8,
  parameter int WGT_W    = 8,
  parameter int INTERVAL = 16,
  localparam int N_REQ = N_TEN * N_CLS,
  localparam int TI_W  = (N_TEN > 1) ? $clog2(N_TEN) : 1,
  localparam int CI_W  = (N_CLS > 1) ? $clog2(N_CLS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [3:0]               cmd_op,
  input  logic [TI_W-1:0]          cmd_tenant,
  input  logic [CI_W-1:0]          cmd_class,
  input  logic [TOK_W-1:0]         cmd_rbw,
  input  logic [WGT_W-1:0]         cmd_wgt,
  output logic                     cmd_done,
  output logic [2:0]               cmd_status,
  output logic [N_TEN*TOK_W-1:0]   cap_rbw,
  input  logic [N_REQ-1:0]         req_valid,
  output logic [N_REQ-1:0]         req_ready
);
  logic [N_TEN-1:0][TOK_W-1:0] ten_rbw, ten_left, cap_arr;
  logic [N_TEN-1:0][WGT_W-1:0] ten_wgt;
  logic [N_REQ-1:0][TOK_W-1:0] cls_rbw, cls_left;
  logic [N_REQ-1:0][WGT_W-1:0] cls_wgt;
  logic                        boundary;

  logic [N_REQ-1:0]            res_elig, grant_res, spare_c, grant_spare;
  logic [N_TEN-1:0]            ten_c, pick1, l2_any;
  logic [N_TEN-1:0][N_CLS-1:0] pick2;
  logic                        l1_any, res_any, spare_go;

  bwshare_cfg #(
    .N_TEN(N_TEN), .N_CLS(N_CLS), .TOK_W(TOK_W), .WGT_W(WGT_W), .INTERVAL(INTERVAL)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_tenant(cmd_tenant), .cmd_class(cmd_class), .cmd_rbw(cmd_rbw),
    .cmd_wgt(cmd_wgt), .cmd_done(cmd_done), .cmd_status(cmd_status),
    .ten_rbw(ten_rbw), .ten_wgt(ten_wgt), .cls_rbw(cls_rbw), .cls_wgt(cls_wgt),
    .cap_rbw(cap_arr)
  );

  assign cap_rbw = cap_arr;

  bwshare_budget #(
    .N_TEN(N_TEN), .N_CLS(N_CLS), .TOK_W(TOK_W), .INTERVAL(INTERVAL)
  ) u_budget (
    .clk(clk), .rst_n(rst_n), .ten_rbw(ten_rbw), .cls_rbw(cls_rbw),
    .grant_res(grant_res), .ten_left(ten_left), .cls_left(cls_left),
    .boundary(boundary)
  );

  // Reserved stage: lowest-index eligible requester.
  for (genvar k = 0; k < N_REQ; k++) begin : g_req
    localparam int T = k / N_CLS;
    localparam int C = k % N_CLS;
    assign res_elig[k]    = req_valid[k] && (cls_left[k] != '0) && (ten_left[T] != '0);
    assign spare_c[k]     = req_valid[k] && (cls_wgt[k] != '0) && (ten_wgt[T] != '0);
    assign grant_spare[k] = spare_go && pick1[T] && pick2[T][C];
  end

  assign res_any   = |res_elig;
  assign grant_res = res_elig & (~res_elig + N_REQ'(1));
  assign spare_go  = !res_any && l1_any;

  // Spare stage, level one: across tenants.
  bwshare_swrr #(.N(N_TEN), .WGT_W(WGT_W)) u_lvl1 (
    .clk(clk), .rst_n(rst_n), .clear(boundary), .advance(spare_go),
    .contend(ten_c), .wgt(ten_wgt), .pick(pick1), .any(l1_any)
  );

  // Spare stage, level two: across classes of each tenant.
  for (genvar t = 0; t < N_TEN; t++) begin : g_ten
    assign ten_c[t] = |spare_c[t*N_CLS +: N_CLS];

    bwshare_swrr #(.N(N_CLS), .WGT_W(WGT_W)) u_lvl2 (
      .clk(clk), .rst_n(rst_n), .clear(boundary), .advance(spare_go && pick1[t]),
      .contend(spare_c[t*N_CLS +: N_CLS]), .wgt(cls_wgt[t*N_CLS +: N_CLS]),
      .pick(pick2[t]), .any(l2_any[t])
    );

    // R9
    hard_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ten_wgt[t] == '0 && ten_left[t] == '0) |-> (req_ready[t*N_CLS +: N_CLS] == '0));

    // R11
    lvl2_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spare_go && pick1[t]) |-> l2_any[t]);
  end

  assign req_ready = grant_res | grant_spare;

  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready) && ((req_ready & ~req_valid) == '0));

  // R7
  res_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_any |-> ((req_ready & ~res_elig) == '0));

  // R12
  work_cons_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_any || (|ten_c)) |-> $countones(req_ready) == 1);
endmodule

// File: tb/bwshare_tb.sv
module bwshare_tb;
  localparam int CLK_P = 10;
  localparam int NT = 2;
  localparam int NC = 2;
  localparam int NR = NT * NC;
  localparam int TW = 8;
  localparam int WW = 8;
  localparam int IV = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [3:0]    cmd_op = '0;
  logic [0:0]    cmd_tenant = '0;
  logic [0:0]    cmd_class = '0;
  logic [TW-1:0] cmd_rbw = '0;
  logic [WW-1:0] cmd_wgt = '0;
  logic          cmd_done;
  logic [2:0]    cmd_status;
  logic [NT*TW-1:0] cap_rbw;
  logic [NR-1:0] req_valid = '0;
  logic [NR-1:0] req_ready;

  always #(CLK_P/2) clk = ~clk;

  bwshare #(.N_TEN(NT), .N_CLS(NC), .TOK_W(TW), .WGT_W(WW), .INTERVAL(IV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_tenant(cmd_tenant), .cmd_class(cmd_class), .cmd_rbw(cmd_rbw),
    .cmd_wgt(cmd_wgt), .cmd_done(cmd_done), .cmd_status(cmd_status),
    .cap_rbw(cap_rbw), .req_valid(req_valid), .req_ready(req_ready)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_cnt, m_done, m_stat;
  int m_tl[NT], m_trbw[NT], m_twgt[NT], m_lock[NT], m_cap[NT], m_c1[NT];
  int m_cl[NR], m_crbw[NR], m_cwgt[NR], m_c2[NR];
  int tally[NR];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic m_reset();
    m_cnt = 0; m_done = 0; m_stat = 0;
    for (int t = 0; t < NT; t++) begin
      m_tl[t] = 0; m_trbw[t] = 0; m_twgt[t] = 0; m_lock[t] = 0; m_cap[t] = IV; m_c1[t] = 0;
    end
    for (int k = 0; k < NR; k++) begin
      m_cl[k] = 0; m_crbw[k] = 0; m_cwgt[k] = 0; m_c2[k] = 0;
    end
  endtask

  task automatic clear_tally();
    for (int k = 0; k < NR; k++) tally[k] = 0;
  endtask

  // Entered at a negedge: drive, compare, advance the model, wait next negedge.
  task automatic step(input logic [NR-1:0] rv, input bit cv, input int op,
                      input int t, input int c, input int rbw, input int w);
    int exp_k, phase, tot, best, bv, tv, b2, pop;
    logic [NR-1:0] expv;
    int c2[NR];
    int c1[NT];
    req_valid = rv; cmd_valid = cv; cmd_op = 4'(op); cmd_tenant = 1'(t);
    cmd_class = 1'(c); cmd_rbw = TW'(rbw); cmd_wgt = WW'(w);
    #1;
    exp_k = -1; phase = 0;
    for (int k = 0; k < NR; k++)
      if (exp_k < 0 && rv[k] && m_cl[k] > 0 && m_tl[k / NC] > 0) begin
        exp_k = k; phase = 1;
      end
    if (exp_k < 0) begin
      for (int q = 0; q < NT; q++) c1[q] = 0;
      for (int k = 0; k < NR; k++) begin
        c2[k] = (rv[k] && m_cwgt[k] != 0 && m_twgt[k / NC] != 0) ? 1 : 0;
        if (c2[k] != 0) c1[k / NC] = 1;
      end
      tot = 0; best = -1; bv = 0;
      for (int q = 0; q < NT; q++) if (c1[q] != 0) begin
        tot += m_twgt[q];
        tv = m_c1[q] + m_twgt[q];
        if (best < 0 || tv > bv) begin best = q; bv = tv; end
      end
      if (best >= 0) begin
        for (int q = 0; q < NT; q++) if (c1[q] != 0) m_c1[q] += m_twgt[q];
        m_c1[best] -= tot;
        tot = 0; b2 = -1; bv = 0;
        for (int r = 0; r < NC; r++) if (c2[best*NC + r] != 0) begin
          tot += m_cwgt[best*NC + r];
          tv = m_c2[best*NC + r] + m_cwgt[best*NC + r];
          if (b2 < 0 || tv > bv) begin b2 = r; bv = tv; end
        end
        for (int r = 0; r < NC; r++)
          if (c2[best*NC + r] != 0) m_c2[best*NC + r] += m_cwgt[best*NC + r];
        m_c2[best*NC + b2] -= tot;
        exp_k = best * NC + b2; phase = 2;
      end
    end
    expv = '0;
    if (exp_k >= 0) expv[exp_k] = 1'b1;
    chk(req_ready == expv, (phase == 1) ? "R7" : ((phase == 2) ? "R11" : "R12"),
        "grant vector", int'(req_ready), int'(expv));
    pop = $countones(req_ready);
    chk(pop <= 1 && (req_ready & ~rv) == '0, "R6", "grant count", pop, 1);
    chk(cmd_done == m_done[0], "R5", "cmd_done", int'(cmd_done), m_done);
    if (m_done != 0) chk(int'(cmd_status) == m_stat, "R4", "cmd_status", int'(cmd_status), m_stat);
    for (int q = 0; q < NT; q++)
      chk(int'(cap_rbw[q*TW +: TW]) == m_cap[q], "R2", "cap_rbw", int'(cap_rbw[q*TW +: TW]), m_cap[q]);
    for (int k = 0; k < NR; k++) if (req_ready[k]) tally[k]++;
    // model clock edge: budgets first, then commands
    if (m_cnt == IV - 1) begin
      m_cnt = 0;
      for (int q = 0; q < NT; q++) begin m_tl[q] = m_trbw[q]; m_c1[q] = 0; end
      for (int k = 0; k < NR; k++) begin m_cl[k] = m_crbw[k]; m_c2[k] = 0; end
    end else begin
      m_cnt++;
      if (phase == 1) begin m_cl[exp_k]--; m_tl[exp_k / NC]--; end
    end
    m_done = cv ? 1 : 0;
    if (cv) begin
      if (op == 4) begin
        if (m_lock[t] != 0) m_stat = 2;
        else begin
          m_trbw[t] = rbw; m_twgt[t] = w; m_lock[t] = 1; m_cap[t] = rbw; m_stat = 0;
        end
      end else if (op == 1) begin
        m_crbw[t*NC + c] = rbw; m_cwgt[t*NC + c] = w; m_stat = 0;
      end else m_stat = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle_to_boundary();
    while (m_cnt != 0) step('0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(req_ready == '0, "R1", "req_ready", int'(req_ready), 0);
    chk(cmd_done == 1'b0, "R1", "cmd_done", int'(cmd_done), 0);
    chk(int'(cap_rbw[TW-1:0]) == IV, "R1", "cap t0", int'(cap_rbw[TW-1:0]), IV);
    chk(int'(cap_rbw[2*TW-1:TW]) == IV, "R1", "cap t1", int'(cap_rbw[2*TW-1:TW]), IV);

    // class settings first (R4), then tenant limits
    step('0, 1, 1, 0, 0, 1, 50);
    step('0, 1, 1, 0, 1, 1, 25);
    step('0, 1, 1, 1, 0, 2, 50);
    step('0, 1, 1, 1, 1, 2, 25);
    step('0, 1, 1, 0, 1, 1, 25);
    chk(cmd_status == 3'd0, "R4", "repeat class status", int'(cmd_status), 0);
    step('0, 1, 4, 0, 1, 4, 16);
    chk(cmd_status == 3'd0, "R2", "limit status", int'(cmd_status), 0);
    chk(int'(cap_rbw[TW-1:0]) == 4, "R2", "cap t0", int'(cap_rbw[TW-1:0]), 4);
    step('0, 1, 4, 0, 0, 9, 3);
    chk(cmd_status == 3'd2, "R3", "repeat limit status", int'(cmd_status), 2);
    chk(int'(cap_rbw[TW-1:0]) == 4, "R3", "cap t0 kept", int'(cap_rbw[TW-1:0]), 4);
    step('0, 1, 4, 1, 0, 3, 0);
    step('0, 1, 7, 0, 0, 0, 0);
    chk(cmd_status == 3'd1, "R4", "bad opcode status", int'(cmd_status), 1);
    idle_to_boundary();

    // two identical intervals, all requesters active
    for (int iv = 0; iv < 2; iv++) begin
      clear_tally();
      repeat (IV) step('1, 0, 0, 0, 0, 0, 0);
      // R11 and R2 (class 1 untouched by opcode 4): 1 reserved + 7 / 4 spare
      chk(tally[0] == 8, (iv == 0) ? "R11" : "R13", "k0 grants", tally[0], 8);
      chk(tally[1] == 5, (iv == 0) ? "R11" : "R13", "k1 grants", tally[1], 5);
      chk(tally[2] + tally[3] == 3, "R9", "capped tenant grants", tally[2] + tally[3], 3);
      chk(tally[2] == 2, (iv == 0) ? "R7" : "R8", "k2 grants", tally[2], 2);
      chk(tally[3] == 1, (iv == 0) ? "R7" : "R8", "k3 grants", tally[3], 1);
    end

    // second configuration: only spare sharing, tenant weights 1 and 2
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    m_reset();
    rst_n = 1'b1;
    #1;
    chk(int'(cap_rbw[TW-1:0]) == IV, "R1", "cap after reset", int'(cap_rbw[TW-1:0]), IV);
    for (int k = 0; k < NR; k++) step('0, 1, 1, k / NC, k % NC, 0, 1);
    step('0, 1, 4, 0, 0, 0, 1);
    step('0, 1, 4, 1, 0, 0, 2);
    idle_to_boundary();
    clear_tally();
    repeat (IV) step('1, 0, 0, 0, 0, 0, 0);
    chk(tally[0] + tally[1] == 5, "R10", "tenant 0 spare", tally[0] + tally[1], 5);
    chk(tally[2] + tally[3] == 11, "R10", "tenant 1 spare", tally[2] + tally[3], 11);
    chk(tally[2] == 6 && tally[3] == 5, "R11", "tenant 1 class k2", tally[2], 6);
    chk(tally[0] + tally[1] + tally[2] + tally[3] == IV, "R12", "total grants",
        tally[0] + tally[1] + tally[2] + tally[3], IV);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule